// File: doc/BRIEF.md
# Filtered Supply Monitor Interrupt Logic

This block is the digital back end of a supply-voltage monitor. It receives one comparator bit that is high while the supply sits above a threshold. It cleans that bit with a two-sample majority filter, which runs on an enable derived from a slow oscillator strobe. It then looks for threshold crossings in a chosen direction. Each qualifying crossing sets a sticky flag. When requests are enabled, the crossing also produces a one-cycle request on either a maskable or a non-maskable output.

Software drives everything through a small register port. The control register holds the monitor enable, the request enable, the filter bypass, the request routing, the sampling divider choice and the direction choice. A second register holds a settling delay, counted in system clocks, that must pass after the monitor is enabled. A third register exposes the sticky flag, which is cleared by writing 0. The filter can be bypassed so that detection still works while the slow strobe is stopped. In bypass mode the comparator bit goes straight to the crossing detector.

Top module: `supmon_irq`

## Requirements
- R1: After reset, all three registers read 0 and both request outputs are low. The registers are: control at address 0, settle at address 1 and flag at address 2. Control and settle read back what was written. Control bit layout: bit0 monitor enable, bit1 request enable, bit2 filter bypass, bit3 route to non-maskable, bits5:4 divider select, bits7:6 direction select.
- R2: While the monitor enable is 0, no crossing is detected. After the monitor is enabled, crossings are accepted only once the settle count of system clocks has elapsed. The level present at that moment is taken as the starting level, without an event.
- R3: Divider select values 0, 1, 2 and 3 give one filter sample every 1, 2, 4 and 8 slow strobes. With the strobe high every cycle, a clean step reaches the request output between P+2 and 2P+1 clocks after the step, where P is the divide ratio.
- R4: With the filter enabled, the filtered level changes only after two consecutive samples agree with each other and differ from the current level. A one-sample pulse is rejected, and a two-sample pulse gives two crossings.
- R5: In bypass mode, crossings are detected with the slow strobe held low. With the filter enabled and no strobe, nothing is detected.
- R6: The filter output counts as valid only after two samples taken since enabling. Level history from before the monitor was disabled never produces a crossing.
- R7: Direction select 00 qualifies falling crossings only (supply dropping below the threshold). 01 qualifies rising crossings only. 10 and 11 qualify both.
- R8: A qualifying crossing sets flag bit0 of address 2 even while the request enable is 0. Writing 0 to bit0 clears it, and writing 1 leaves it unchanged. The flag becomes 1 in the same cycle the request pulse is issued.
- R9: When a qualifying crossing and a flag-clearing write fall in the same cycle, the flag ends up set.
- R10: A crossing that occurs while the request enable is 0 produces no request, either then or after the enable is later set.
- R11: Each qualifying crossing with the request enable at 1 gives a single one-cycle pulse. The pulse goes to the maskable output when control bit3 is 0 and to the non-maskable output when it is 1, never to both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| cmp_above | input | 1 | Comparator bit, high when supply is above threshold (already synchronous) |
| slow_tick | input | 1 | One-cycle strobe per slow oscillator period |
| irq_maskable | output | 1 | Maskable request pulse |
| irq_nmi | output | 1 | Non-maskable request pulse |

## Verification
The sticky flag has two writers that can act in the same cycle: a qualifying crossing sets it and a software write of 0 clears it. The bench provokes the collision in bypass mode. It flips the comparator bit just before one edge and places the flag-clearing write on the following edge, which is exactly when the crossing reaches the flag. The flag must read 1 afterwards, and the request must still appear exactly once. A control case moves the write one cycle later and expects the flag to read 0.

// File: rtl/supmon_pkg.sv
// Shared register addresses and the control register layout for the supply
// monitor interrupt logic.
package supmon_pkg;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_SETTLE = 2'd1;
    localparam logic [1:0] ADDR_FLAG   = 2'd2;

    // Direction select encodings (bit1 set means both directions)
    localparam logic [1:0] DIR_FALL = 2'b00;
    localparam logic [1:0] DIR_RISE = 2'b01;

    // Control register, MSB first: [7:6] dir_sel, [5:4] div_sel, [3] nmi_sel,
    // [2] bypass, [1] irq_en, [0] mon_en
    typedef struct packed {
        logic [1:0] dir_sel;
        logic [1:0] div_sel;
        logic       nmi_sel;
        logic       bypass;
        logic       irq_en;
        logic       mon_en;
    } ctrl_t;

    localparam int REG_W = $bits(ctrl_t);

endpackage

// File: rtl/supmon_regs.sv
// Register file: control, settle count and the sticky detection flag.
// Assumes single-cycle writes; reads are combinational. A flag set request
// wins over a clearing write in the same cycle.
module supmon_regs
    import supmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             flag_set,
    output logic [REG_W-1:0] rd_data,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] settle,
    output logic             flag
);

    // Control and settle registers take software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            settle <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL)   ctrl   <= ctrl_t'(wr_data);
            if (wr_addr == ADDR_SETTLE) settle <= wr_data;
        end
    end

    // Sticky flag: hardware set has priority over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (flag_set)
            flag <= 1'b1;
        else if (wr_en && wr_addr == ADDR_FLAG && !wr_data[0])
            flag <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        case (rd_addr)
            ADDR_CTRL:   rd_data = ctrl;
            ADDR_SETTLE: rd_data = settle;
            ADDR_FLAG:   rd_data = {{(REG_W-1){1'b0}}, flag};
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/supmon_settle.sv
// Settling timer: after the monitor is enabled, counts system clocks up to
// the programmed limit and then reports the detector ready. Disabling the
// monitor restarts the count.
module supmon_settle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] limit,
    output logic             ready
);

    logic [CNT_W-1:0] cnt;

    // Count up while enabled, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cnt <= '0;
        else if (cnt < limit)
            cnt <= cnt + 1'b1;
    end

    assign ready = enable && (cnt >= limit);

endmodule

// File: rtl/supmon_filter.sv
// Sampling divider, two-sample agreement filter and crossing detector.
// Assumes cmp is already synchronous to clk. The divider turns the slow
// strobe into a sample enable every 2**div_sel strobes. Outside bypass, the
// level moves only when two consecutive samples agree and differ from it.
// In bypass the raw bit is followed every clock. Any loss of 'active' or a
// change of bypass mode discards the level history, so no stale crossing
// can appear. Crossing pulses are registered and last one clock.
module supmon_filter #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             bypass,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             slow_tick,
    input  logic             cmp,
    output logic             ev_rise,
    output logic             ev_fall
);

    localparam int DIV_CNT_W = (1 << SEL_W) - 1;
    localparam logic [1:0] NS_EMPTY = 2'd0;
    localparam logic [1:0] NS_ONE   = 2'd1;

    logic [DIV_CNT_W-1:0] div_cnt;
    logic [DIV_CNT_W-1:0] div_mask;
    logic                 samp;
    logic [1:0]           nsamp;
    logic                 prev;
    logic                 lvl;
    logic                 byp_q;

    // Free-running strobe counter for the divider
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (slow_tick)
            div_cnt <= div_cnt + 1'b1;
    end

    // Low div_sel bits of the counter must all be ones to take a sample
    always_comb begin
        for (int i = 0; i < DIV_CNT_W; i++)
            div_mask[i] = (i < int'(div_sel));
    end

    assign samp = slow_tick && ((div_cnt & div_mask) == div_mask);

    // Level tracking and crossing detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsamp   <= NS_EMPTY;
            prev    <= 1'b0;
            lvl     <= 1'b0;
            byp_q   <= 1'b0;
            ev_rise <= 1'b0;
            ev_fall <= 1'b0;
        end else begin
            ev_rise <= 1'b0;
            ev_fall <= 1'b0;
            byp_q   <= bypass;
            if (!active || bypass != byp_q) begin
                nsamp <= NS_EMPTY;
            end else if (bypass) begin
                if (nsamp == NS_EMPTY) begin
                    lvl   <= cmp;
                    nsamp <= 2'd2;
                end else if (cmp != lvl) begin
                    lvl     <= cmp;
                    ev_rise <= cmp;
                    ev_fall <= !cmp;
                end
            end else if (samp) begin
                prev <= cmp;
                if (nsamp == NS_EMPTY) begin
                    nsamp <= NS_ONE;
                end else if (nsamp == NS_ONE) begin
                    if (prev == cmp) begin
                        lvl   <= cmp;
                        nsamp <= 2'd2;
                    end
                end else if (prev == cmp && cmp != lvl) begin
                    lvl     <= cmp;
                    ev_rise <= cmp;
                    ev_fall <= !cmp;
                end
            end
        end
    end

endmodule

// File: rtl/supmon_irq.sv
// Top of the supply monitor interrupt logic. Joins the register file, the
// settling timer and the filter. Qualifies crossings by direction and issues
// a one-clock request on the selected output when requests are enabled.
// Assumes cmp_above is synchronous to clk.
module supmon_irq
    import supmon_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             cmp_above,
    input  logic             slow_tick,
    output logic             irq_maskable,
    output logic             irq_nmi
);

    ctrl_t            ctrl;
    logic [REG_W-1:0] settle;
    logic             flag;
    logic             ready;
    logic             ev_rise;
    logic             ev_fall;
    logic             qual;

    supmon_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .flag_set (qual),
        .rd_data  (rd_data),
        .ctrl     (ctrl),
        .settle   (settle),
        .flag     (flag)
    );

    supmon_settle #(.CNT_W(REG_W)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ctrl.mon_en),
        .limit  (settle),
        .ready  (ready)
    );

    supmon_filter #(.SEL_W(SEL_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (ready),
        .bypass    (ctrl.bypass),
        .div_sel   (SEL_W'(ctrl.div_sel)),
        .slow_tick (slow_tick),
        .cmp       (cmp_above),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall)
    );

    // Direction qualification of the crossing pulses
    always_comb begin
        if (ctrl.dir_sel[1])
            qual = ev_rise || ev_fall;
        else if (ctrl.dir_sel == DIR_RISE)
            qual = ev_rise;
        else
            qual = ev_fall;
    end

    // Request pulse, routed by the type select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_maskable <= 1'b0;
            irq_nmi      <= 1'b0;
        end else begin
            irq_maskable <= qual && ctrl.irq_en && !ctrl.nmi_sel;
            irq_nmi      <= qual && ctrl.irq_en && ctrl.nmi_sel;
        end
    end

endmodule

// File: rtl/supmon_irq_chk.sv
// Assertion checker for supmon_irq, attached by bind. Watches the control
// register, the qualified crossing, the sticky flag and the request outputs.
module supmon_irq_chk
    import supmon_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input ctrl_t      ctrl,
    input logic       qual,
    input logic       flag,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       wr_data0,
    input logic       irq_maskable,
    input logic       irq_nmi
);

    logic clr_wr;
    logic irq_any;
    assign clr_wr  = wr_en && wr_addr == ADDR_FLAG && !wr_data0;
    assign irq_any = irq_maskable || irq_nmi;

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_maskable && irq_nmi));

    a_r11_nmi_route: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nmi |-> $past(ctrl.nmi_sel));

    a_r11_mask_route: assert property (@(posedge clk) disable iff (!rst_n)
        irq_maskable |-> !$past(ctrl.nmi_sel));

    a_r10_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> $past(ctrl.irq_en));

    a_r8_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> flag);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> flag);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !qual) |=> !flag);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl.mon_en, 2) |-> !irq_any);

endmodule

bind supmon_irq supmon_irq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .qual         (qual),
    .flag         (flag),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data0     (wr_data[0]),
    .irq_maskable (irq_maskable),
    .irq_nmi      (irq_nmi)
);

// File: tb/supmon_irq_test.sv
// Self-checking bench for supmon_irq: sweeps direction, enable and routing
// in bypass, sweeps the divider, and probes the filter and flag corners.
module supmon_irq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       cmp_above = 1'b0;
    logic       slow_tick = 1'b1;
    logic       irq_maskable;
    logic       irq_nmi;

    int n_checks = 0;
    int n_errors = 0;
    int tot_mask = 0;
    int tot_nmi  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    supmon_irq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .cmp_above    (cmp_above),
        .slow_tick    (slow_tick),
        .irq_maskable (irq_maskable),
        .irq_nmi      (irq_nmi)
    );

    // Pulse totals, sampled away from the active edge
    always @(negedge clk) begin
        tot_mask = tot_mask + int'(irq_maskable);
        tot_nmi  = tot_nmi + int'(irq_nmi);
    end

    function automatic logic [7:0] mk(input bit mon, input bit ien, input bit byp,
                                      input bit nmi, input int dv, input int dir);
        return {2'(dir), 2'(dv), nmi, byp, ien, mon};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int bm;
        int bn;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, d); check(d == 8'd0, "R1", "ctrl after reset", d, 0);
        rd(2'd1, d); check(d == 8'd0, "R1", "settle after reset", d, 0);
        rd(2'd2, d); check(d == 8'd0, "R1", "flag after reset", d, 0);
        check(!irq_maskable && !irq_nmi, "R1", "requests after reset",
              int'(irq_maskable | irq_nmi), 0);

        // R1 readback
        wr(2'd1, 8'h5A); rd(2'd1, d); check(d == 8'h5A, "R1", "settle readback", d, 'h5A);
        wr(2'd0, mk(0, 1, 0, 1, 2, 3)); rd(2'd0, d);
        check(d == mk(0, 1, 0, 1, 2, 3), "R1", "ctrl readback", d, mk(0, 1, 0, 1, 2, 3));
        wr(2'd0, 8'd0); wr(2'd1, 8'd0);

        // R7 R8 R11 sweep in bypass mode
        for (int dir = 0; dir < 4; dir++)
            for (int fall = 0; fall < 2; fall++)
                for (int ien = 0; ien < 2; ien++)
                    for (int nmi = 0; nmi < 2; nmi++) begin
                        bit q;
                        wr(2'd0, 8'd0);
                        cmp_above = (fall == 1);
                        wr(2'd2, 8'd0);
                        wr(2'd0, mk(1, ien[0], 1, nmi[0], 0, dir));
                        idle(3);
                        bm = tot_mask; bn = tot_nmi;
                        cmp_above = ~cmp_above;
                        idle(4);
                        q = (dir >= 2) || (dir == 0 && fall == 1) || (dir == 1 && fall == 0);
                        rd(2'd2, d);
                        check(d[0] == q, "R7", "flag per direction", d[0], q);
                        check(tot_mask - bm == int'(q && ien == 1 && nmi == 0), "R11",
                              "maskable count", tot_mask - bm, int'(q && ien == 1 && nmi == 0));
                        check(tot_nmi - bn == int'(q && ien == 1 && nmi == 1), "R11",
                              "nmi count", tot_nmi - bn, int'(q && ien == 1 && nmi == 1));
                    end

        // R2 monitor disabled: no detection
        wr(2'd0, 8'd0); wr(2'd2, 8'd0);
        wr(2'd0, mk(0, 1, 1, 0, 0, 2));
        bm = tot_mask;
        cmp_above = ~cmp_above; idle(3); cmp_above = ~cmp_above; idle(3);
        rd(2'd2, d);
        check(d[0] == 1'b0 && tot_mask == bm, "R2", "disabled monitor quiet", d[0], 0);

        // R2 settle delay
        wr(2'd1, 8'd20); wr(2'd0, 8'd0);
        cmp_above = 1'b1; wr(2'd2, 8'd0);
        wr(2'd0, mk(1, 1, 1, 0, 0, 2));
        bm = tot_mask;
        idle(4); cmp_above = 1'b0; idle(6);
        rd(2'd2, d); check(d[0] == 1'b0, "R2", "no event while settling", d[0], 0);
        idle(20);
        rd(2'd2, d); check(d[0] == 1'b0, "R2", "start level taken silently", d[0], 0);
        cmp_above = 1'b1; idle(4);
        rd(2'd2, d); check(d[0] == 1'b1, "R2", "event after settling", d[0], 1);
        check(tot_mask - bm == 1, "R2", "request after settling", tot_mask - bm, 1);
        wr(2'd1, 8'd0);

        // R3 divider latency sweep
        for (int f = 0; f < 4; f++) begin
            int p;
            int n;
            p = 1 << f;
            wr(2'd0, 8'd0); cmp_above = 1'b0; wr(2'd2, 8'd0);
            wr(2'd0, mk(1, 1, 0, 0, f, 1));
            idle(40);
            cmp_above = 1'b1;
            n = 0;
            while (n < 40) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (irq_maskable) break;
            end
            check(n >= p + 2 && n <= 2 * p + 1, "R3", "step latency low bound", n, p + 2);
        end

        // R4 one-sample glitch rejected, two-sample pulse passes
        wr(2'd0, 8'd0); cmp_above = 1'b0;
        wr(2'd0, mk(1, 1, 0, 0, 0, 2));
        idle(6);
        bm = tot_mask;
        cmp_above = 1'b1; idle(1); cmp_above = 1'b0; idle(6);
        check(tot_mask == bm, "R4", "single-sample glitch", tot_mask - bm, 0);
        bm = tot_mask;
        cmp_above = 1'b1; idle(2); cmp_above = 1'b0; idle(6);
        check(tot_mask - bm == 2, "R4", "two-sample pulse", tot_mask - bm, 2);

        // R5 no strobe: filter idle, bypass still detects
        slow_tick = 1'b0;
        wr(2'd0, 8'd0); cmp_above = 1'b0;
        wr(2'd0, mk(1, 1, 0, 0, 0, 2));
        idle(4); bm = tot_mask;
        cmp_above = 1'b1; idle(10);
        check(tot_mask == bm, "R5", "filter without strobe", tot_mask - bm, 0);
        wr(2'd0, 8'd0); cmp_above = 1'b0;
        wr(2'd0, mk(1, 1, 1, 0, 0, 1));
        idle(3); bm = tot_mask;
        cmp_above = 1'b1; idle(4);
        check(tot_mask - bm == 1, "R5", "bypass without strobe", tot_mask - bm, 1);
        slow_tick = 1'b1;

        // R6 stale level history never fires
        wr(2'd0, 8'd0); cmp_above = 1'b1; wr(2'd2, 8'd0);
        wr(2'd0, mk(1, 1, 0, 0, 0, 0));
        idle(8);
        wr(2'd0, 8'd0);
        cmp_above = 1'b0; idle(3);
        bm = tot_mask;
        wr(2'd0, mk(1, 1, 0, 0, 0, 0));
        idle(12);
        rd(2'd2, d);
        check(d[0] == 1'b0 && tot_mask == bm, "R6", "no stale crossing", tot_mask - bm, 0);
        cmp_above = 1'b1; idle(6); cmp_above = 1'b0; idle(6);
        check(tot_mask - bm == 1, "R6", "fresh fall after revalidation", tot_mask - bm, 1);

        // R10 crossing while requests disabled
        wr(2'd0, 8'd0); cmp_above = 1'b0; wr(2'd2, 8'd0);
        wr(2'd0, mk(1, 0, 1, 0, 0, 2));
        idle(3); bm = tot_mask;
        cmp_above = 1'b1; idle(4);
        rd(2'd2, d); check(d[0] == 1'b1, "R8", "flag set with requests off", d[0], 1);
        check(tot_mask == bm, "R10", "no request while disabled", tot_mask - bm, 0);
        wr(2'd0, mk(1, 1, 1, 0, 0, 2));
        idle(10);
        check(tot_mask == bm, "R10", "no late request on enable", tot_mask - bm, 0);

        // R8 flag write semantics
        wr(2'd2, 8'h01); rd(2'd2, d); check(d[0] == 1'b1, "R8", "write 1 keeps set", d[0], 1);
        wr(2'd2, 8'h00); rd(2'd2, d); check(d[0] == 1'b0, "R8", "write 0 clears", d[0], 0);
        wr(2'd2, 8'h01); rd(2'd2, d); check(d[0] == 1'b0, "R8", "write 1 keeps clear", d[0], 0);

        // R9 set and clear in the same cycle
        bm = tot_mask;
        cmp_above = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd2, d); check(d[0] == 1'b1, "R9", "set wins over clear", d[0], 1);
        idle(2);
        check(tot_mask - bm == 1, "R9", "request during collision", tot_mask - bm, 1);

        // R8 control case: clear one cycle after the set
        cmp_above = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd2, d); check(d[0] == 1'b0, "R8", "later clear takes effect", d[0], 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule